// File: doc/BRIEF.md
# Latency-Programmed Block Read Buffer

This block sits between a memory array and a small cache. On a transfer command it takes an eight-word, 16-bit-per-word block from the array side into a first holding stage. The block is copied into a second, host-visible stage only after a programmed number of active clock cycles. Until then the host keeps seeing the block that was there before. The host can pick any one word out of the second stage through a 3-bit selector, or take the whole stage as one wide bus in the same cycle, for example to fill a cache row.

Commands arrive on a valid/ready port with a 2-bit opcode. Back-pressure rules: a command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low whenever the memory side is powered down (`mem_pd` high). It is also low for the three cycles that follow an accepted latency setting. The source holds its command until it is taken. Cycles spent in power-down freeze the latency count. A transfer issued while another is still counting replaces it and restarts the count.

Top module: `rbuf_top`

## Requirements
- R1: After a transfer is accepted, `blk_out` keeps its previous value in every cycle until the update edge.
- R2: With programmed latency L, `blk_out` takes the captured block on the L-th counted rising edge after the accepting edge. A counted edge is one where `mem_pd` is low.
- R3: While `mem_pd` is high, `cmd_ready` is low, the latency count does not advance, and `blk_out` and `pending` hold.
- R4: `rd_word` equals word `word_sel` of `blk_out`. Word k sits at bits [16k+15:16k].
- R5: In the same cycle, `rd_word` and the full `blk_out` are both valid, so one cycle can deliver the block and an addressed word together.
- R6: Opcode 01 (write with read) captures `blk_in` and updates stage two exactly as opcode 00 (read transfer) does.
- R7: Opcode 10 with `cfg_val` from 1 to 4 sets the latency. `cmd_ready` is low for the 3 cycles after the accepting cycle. Transfers accepted after that window use the new value.
- R8: Opcode 10 with `cfg_val` of 0, 5, 6 or 7 is ignored. The latency is unchanged and no ready window occurs.
- R9: A transfer accepted while `pending` is high restarts the count with the new block. The superseded block never appears on `blk_out`.
- R10: `pending` is high from the edge that accepts a transfer until the edge that updates stage two.
- R11: After reset, `blk_out` is zero, `pending` is low, the latency is 2, and `cmd_ready` follows `!mem_pd`.
- R12: Opcode 11 is a no-op that changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_pd | input | 1 | Memory side powered down this cycle |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 00 read transfer, 01 write with read, 10 set latency, 11 no-op |
| cfg_val | input | 3 | Latency value for opcode 10 |
| blk_in | input | 128 | Block from the array side, word k at [16k+15:16k] |
| word_sel | input | 3 | Word index into stage two |
| blk_out | output | 128 | Stage-two block |
| rd_word | output | 16 | Selected stage-two word |
| pending | output | 1 | A transfer is waiting for its latency to expire |

## Verification
The bench targets the edge at which stage two flips, across all four latencies. A design that is off by one cycle would expose the new block a cycle early or late, and `blk_out` would disagree at that cycle. Power-down cycles are placed inside the latency window: a counter that kept running through them would update stage two too early. Back-to-back transfers check that a restart discards the older block instead of showing it briefly. Illegal and legal latency settings are issued in mid-traffic: a design that took an illegal value, or applied a legal one before the three-cycle window ended, would mistime the next transfer or raise `cmd_ready` at the wrong time.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  typedef enum logic [1:0] {
    OP_RDX = 2'b00,
    OP_WRX = 2'b01,
    OP_CFG = 2'b10,
    OP_NOP = 2'b11
  } rbuf_op_e;
endpackage

// File: rtl/rbuf_lat_cfg.sv
module rbuf_lat_cfg #(
  parameter int LAT_W   = 3,
  parameter int LAT_MAX = 4,
  parameter int LAT_RST = 2,
  parameter int SETTLE  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] val,
  output logic [LAT_W-1:0] lat,
  output logic             busy
);
  localparam int SW = $clog2(SETTLE + 1);
  logic [SW-1:0]    settle_q;
  logic [LAT_W-1:0] staged_q;
  logic             legal;

  assign legal = (val >= LAT_W'(1)) && (val <= LAT_W'(LAT_MAX));
  assign busy  = (settle_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle_q <= '0;
      staged_q <= LAT_W'(LAT_RST);
      lat      <= LAT_W'(LAT_RST);
    end else if (load && legal) begin
      settle_q <= SW'(SETTLE);
      staged_q <= val;
    end else if (busy) begin
      settle_q <= settle_q - 1'b1;
      if (settle_q == SW'(1)) lat <= staged_q;
    end
  end
endmodule

// File: rtl/rbuf_lat_ctr.sv
module rbuf_lat_ctr #(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pd,
  input  logic [LAT_W-1:0] lat,
  output logic             pending,
  output logic             update
);
  logic [LAT_W-1:0] cnt_q;

  assign update = pending && !pd && !start && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else if (start) begin
      cnt_q   <= lat - 1'b1;
      pending <= 1'b1;
    end else if (pending && !pd) begin
      if (cnt_q == '0) pending <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rbuf_stage.sv
module rbuf_stage #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 8,
  localparam int BLK_W = WORD_W * NWORDS,
  localparam int SEL_W = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             update,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [SEL_W-1:0] sel,
  output logic [BLK_W-1:0] blk_out,
  output logic [WORD_W-1:0] word
);
  logic [BLK_W-1:0]  s1_q;
  logic [WORD_W-1:0] words [NWORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q    <= '0;
      blk_out <= '0;
    end else begin
      if (cap)    s1_q    <= blk_in;
      if (update) blk_out <= s1_q;
    end
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_w
    assign words[k] = blk_out[k*WORD_W +: WORD_W];
  end

  assign word = words[sel];
endmodule

// File: rtl/rbuf_top.sv
module rbuf_top #(
  parameter int WORD_W  = 16,
  parameter int NWORDS  = 8,
  parameter int LAT_W   = 3,
  parameter int LAT_MAX = 4,
  parameter int LAT_RST = 2,
  parameter int SETTLE  = 3,
  localparam int BLK_W  = WORD_W * NWORDS,
  localparam int SEL_W  = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_pd,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [LAT_W-1:0]  cfg_val,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [SEL_W-1:0]  word_sel,
  output logic [BLK_W-1:0]  blk_out,
  output logic [WORD_W-1:0] rd_word,
  output logic              pending
);
  import rbuf_pkg::*;

  logic             fire, xfer, cfg_load, busy, update;
  logic [LAT_W-1:0] lat;

  assign cmd_ready = !mem_pd && !busy;
  assign fire      = cmd_valid && cmd_ready;
  assign xfer      = fire && ((cmd_op == OP_RDX) || (cmd_op == OP_WRX));
  assign cfg_load  = fire && (cmd_op == OP_CFG);

  rbuf_lat_cfg #(.LAT_W(LAT_W), .LAT_MAX(LAT_MAX), .LAT_RST(LAT_RST), .SETTLE(SETTLE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .val(cfg_val), .lat(lat), .busy(busy)
  );

  rbuf_lat_ctr #(.LAT_W(LAT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(xfer), .pd(mem_pd), .lat(lat),
    .pending(pending), .update(update)
  );

  rbuf_stage #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_stage (
    .clk(clk), .rst_n(rst_n), .cap(xfer), .update(update), .blk_in(blk_in),
    .sel(word_sel), .blk_out(blk_out), .word(rd_word)
  );
endmodule

// File: rtl/rbuf_chk.sv
module rbuf_chk #(
  parameter int LAT_W = 3,
  parameter int LAT_MAX = 4,
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_pd,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [LAT_W-1:0] cfg_val,
  input logic [BLK_W-1:0] blk_out,
  input logic             pending
);
  logic acc, acc_x, good;
  assign acc   = cmd_valid && cmd_ready;
  assign acc_x = acc && !cmd_op[1];
  assign good  = (cfg_val >= LAT_W'(1)) && (cfg_val <= LAT_W'(LAT_MAX));

  // R3
  pd_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_pd |-> !cmd_ready);
  // R3
  pd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pd && pending) |=> (pending && $stable(blk_out)));
  // R7
  cfg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'b10 && good) |=> !cmd_ready);
  // R8
  cfg_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'b10 && !good) |=> (cmd_ready || mem_pd));
  // R10
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_x |=> pending);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !acc_x) |=> $stable(blk_out));
endmodule

bind rbuf_top rbuf_chk #(.LAT_W(LAT_W), .LAT_MAX(LAT_MAX), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_pd(mem_pd), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cfg_val(cfg_val), .blk_out(blk_out), .pending(pending)
);

// File: tb/sim_rbuf_top.sv
module sim_rbuf_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mem_pd = 1'b0, cmd_valid = 1'b0, cmd_ready;
  logic [1:0]   cmd_op = 2'b11;
  logic [2:0]   cfg_val = 3'd0, word_sel = 3'd0;
  logic [127:0] blk_in = '0, blk_out;
  logic [15:0]  rd_word;
  logic         pending;

  int n_chk = 0, n_bad = 0;

  logic [127:0] m_s1 = '0, m_s2 = '0;
  int m_cnt = 0, m_lat = 2, m_stg = 2, m_settle = 0;
  bit m_pend = 0;

  always #4 clk = ~clk;

  rbuf_top u0 (
    .clk(clk), .rst_n(rst_n), .mem_pd(mem_pd), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cfg_val(cfg_val), .blk_in(blk_in), .word_sel(word_sel),
    .blk_out(blk_out), .rd_word(rd_word), .pending(pending)
  );

  function automatic bit exp_ready();
    return !mem_pd && (m_settle == 0);
  endfunction

  function automatic logic [15:0] exp_word(logic [127:0] b, logic [2:0] s);
    return b[s*16 +: 16];
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all();
    chk("R7 cmd_ready", 128'(cmd_ready), 128'(exp_ready()));
    chk("R10 pending", 128'(pending), 128'(m_pend));
    chk("R2 blk_out", blk_out, m_s2);
    chk("R4 rd_word", 128'(rd_word), 128'(exp_word(m_s2, word_sel)));
    chk("R5 word vs block", 128'(rd_word), 128'(exp_word(blk_out, word_sel)));
  endtask

  // model step for one rising edge, using inputs held through it
  task automatic model_edge();
    bit f = cmd_valid && exp_ready();
    int v = int'(cfg_val);
    if (f && !cmd_op[1]) begin
      m_s1 = blk_in; m_cnt = m_lat - 1; m_pend = 1;
    end else if (m_pend && !mem_pd) begin
      if (m_cnt == 0) begin m_s2 = m_s1; m_pend = 0; end
      else m_cnt--;
    end
    if (f && cmd_op == 2'b10 && v >= 1 && v <= 4) begin
      m_stg = v; m_settle = 3;
    end else if (m_settle != 0) begin
      if (m_settle == 1) m_lat = m_stg;
      m_settle--;
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [2:0] cv, logic [127:0] b, bit pd, logic [2:0] s);
    cmd_valid = v; cmd_op = op; cfg_val = cv; blk_in = b; mem_pd = pd; word_sel = s;
    #1 chk_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  function automatic logic [127:0] rblk();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : watchdog
    #1500000;
    n_bad++; n_chk++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] a, b;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    #1 chk("R11 blk_out", blk_out, '0);
    chk("R11 pending", 128'(pending), 128'(0));
    chk("R11 ready", 128'(cmd_ready), 128'(1));
    // R2 default latency 2, R1 old block held
    a = rblk();
    step(1, 2'b00, 0, a, 0, 3'd5);
    chk("R1 old block held", blk_out, '0);
    step(0, 2'b11, 0, '0, 0, 3'd5);
    chk("R1 still old", blk_out, '0);
    step(0, 2'b11, 0, '0, 0, 3'd5);
    chk("R2 flip at L=2", blk_out, a);
    // R3 pd freeze inside window
    b = rblk();
    step(1, 2'b01, 0, b, 0, 3'd0);
    step(0, 2'b11, 0, '0, 1, 3'd1);
    step(0, 2'b11, 0, '0, 1, 3'd1);
    chk("R3 frozen", blk_out, a);
    step(0, 2'b11, 0, '0, 0, 3'd1);
    step(0, 2'b11, 0, '0, 0, 3'd1);
    chk("R6 write-with-read block", blk_out, b);
    // R8 illegal config ignored
    step(1, 2'b10, 3'd6, '0, 0, 0);
    chk("R8 no window", 128'(cmd_ready), 128'(1));
    // R9 restart
    a = rblk(); b = rblk();
    step(1, 2'b00, 0, a, 0, 0);
    step(1, 2'b00, 0, b, 0, 0);
    step(0, 2'b11, 0, '0, 0, 0);
    chk("R9 superseded hidden", 128'(blk_out == a), 128'(0));
    step(0, 2'b11, 0, '0, 0, 0);
    chk("R9 new block", blk_out, b);
    // R7 legal configs, each latency
    for (int l = 4; l >= 1; l--) begin
      step(1, 2'b10, 3'(l), '0, 0, 0);
      chk("R7 window", 128'(cmd_ready), 128'(0));
      repeat (3) step(1, 2'b00, 0, rblk(), 0, 0);
      a = rblk();
      step(1, 2'b00, 0, a, 0, 3'd7);
      for (int k = 0; k < l; k++) step(0, 2'b11, 0, '0, 0, 3'd7);
      chk("R7 new latency", blk_out, a);
    end
    // R12 no-op
    step(1, 2'b11, 0, rblk(), 0, 0);
    chk("R12 nop", blk_out, a);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      logic [1:0] op = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r < 7) ? 2'b10 : 2'b11;
      step($urandom_range(0, 3) != 0, op, 3'($urandom_range(0, 7)), rblk(),
           $urandom_range(0, 4) == 0, 3'($urandom_range(0, 7)));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule